// File: doc/BRIEF.md
# Sampler Configuration Controller

This block sits between the user controls of a microphone-array sampling board and the sampler datapath. It takes single-cycle press pulses from three already debounced buttons (delay up, delay down, mode step), four slide-switch levels and four FIFO fill flags. From these it keeps the configuration the sampler needs and drives the status LEDs.

The configuration has three parts. The first is a saturating sample-delay index that starts at 8. The second is a data mode that steps through three settings in a fixed cycle. The third is an array count and a board identifier, both decoded from the switches. A row of four LEDs shows the delay index in binary. Two RGB LEDs show the data mode as a colour, and FIFO fill conditions appear as colours mixed on top of it. The sampler reads the delay index, the mode and the array count. The processor side reads the board identifier and uses it to pick a per-board network address.

Top module: `sampler_cfg_ctrl`

## Requirements
- R1: While reset is held and after its release, the delay index is 8, the mode code is 0, the array count is 1 and the board identifier is 0, whatever the switches show.
- R2: One delay-up pulse raises the delay index by one. One delay-down pulse lowers it by one. The new value is visible one clock edge after the pulse.
- R3: The delay index stays at 15 on further up pulses and stays at 0 on further down pulses. It never wraps.
- R4: The delay LEDs show the delay index in binary with bit 3 on LED 3, so the reset value lights only LED 3 (pattern 1000).
- R5: Each mode pulse advances the mode code in the order 0 (real data, sign padding), then 1 (simulated data, mic-ID padding), then 2 (real data, mic-ID padding), then back to 0. The new code is visible one edge after the pulse.
- R6: Each RGB LED is a 3-bit vector with red on bit 2, green on bit 1 and blue on bit 0. With no FIFO flag set, mode 0 lights nothing, mode 1 lights both LEDs red (100), and mode 2 lights both yellow (110).
- R7: The array count is the 2-bit value of switches 1:0 plus one, with switch 1 as the MSB, giving 1 to 4. It is registered, so a switch change shows one edge later.
- R8: The board identifier is the 2-bit value of switches 3:2, with switch 3 as the MSB. It is registered the same way as the array count.
- R9: FIFO flags light colours without delay. Empty turns on blue on RGB LED B, almost empty turns on green on B, almost full turns on red on RGB LED A, and full turns on blue on A. Several flags set at once combine bitwise.
- R10: In modes 1 and 2 the mode colour and the FIFO colours are ORed on each RGB LED.
- R11: A delay-up and a delay-down pulse in the same cycle leave the delay index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| incPress | input | 1 | Delay-up press pulse, one cycle |
| decPress | input | 1 | Delay-down press pulse, one cycle |
| modePress | input | 1 | Mode-step press pulse, one cycle |
| switches | input | 4 | Slide switch levels; 1:0 select array count, 3:2 board id |
| fifoEmpty | input | 1 | FIFO empty flag |
| fifoAlmostEmpty | input | 1 | FIFO almost-empty flag |
| fifoAlmostFull | input | 1 | FIFO almost-full flag |
| fifoFull | input | 1 | FIFO full flag |
| delayIdx | output | 4 | Current sample-delay index |
| dataMode | output | 2 | Data mode code 0, 1 or 2 |
| arrayCount | output | 3 | Number of connected arrays, 1 to 4 |
| boardId | output | 2 | Board identifier for the processor side |
| delayLeds | output | 4 | Binary display of the delay index |
| rgbA | output | 3 | RGB LED A, {red, green, blue} |
| rgbB | output | 3 | RGB LED B, {red, green, blue} |

## Verification
The bench drives the delay index into both ends and keeps pressing past them. A counter without saturation would wrap to 0 or 15 at that point. It presses up and down in the same cycle, where a design that gave either button priority would move the index. It steps the mode through a full cycle and then some, which exposes a wrong order or a missing return to code 0. It checks the switch-derived outputs one cycle after a change and at reset with nonzero switches, so a missing "+1", swapped bits or an unregistered path all show up. It sets FIFO flags singly, in pairs and on top of each mode colour, which catches a swapped LED, a swapped colour or a colour that replaces the mode colour instead of being ORed with it.

// File: rtl/sampler_cfg_pkg.sv
package sampler_cfg_pkg;

  typedef enum logic [1:0] {
    MODE_REAL_SIGN = 2'd0,
    MODE_SIM_ID    = 2'd1,
    MODE_REAL_ID   = 2'd2
  } dataMode_e;

  typedef struct packed {
    logic delayUp;
    logic delayDown;
  } ctrlStrobes_t;

  localparam int RGB_W   = 3;
  localparam int RED_BIT = 2;
  localparam int GRN_BIT = 1;
  localparam int BLU_BIT = 0;

endpackage

// File: rtl/sampler_cfg_control.sv
module sampler_cfg_control
  import sampler_cfg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         incPress,
  input  logic         decPress,
  input  logic         modePress,
  output ctrlStrobes_t strobes,
  output dataMode_e    modeState
);

  dataMode_e modeNext;

  // Opposing presses in one cycle cancel out.
  always_comb begin
    strobes.delayUp   = incPress & ~decPress;
    strobes.delayDown = decPress & ~incPress;
  end

  always_comb begin
    modeNext = modeState;
    if (modePress) begin
      unique case (modeState)
        MODE_REAL_SIGN: modeNext = MODE_SIM_ID;
        MODE_SIM_ID:    modeNext = MODE_REAL_ID;
        MODE_REAL_ID:   modeNext = MODE_REAL_SIGN;
        default:        modeNext = MODE_REAL_SIGN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeState <= MODE_REAL_SIGN;
    else       modeState <= modeNext;
  end

endmodule

// File: rtl/sampler_cfg_datapath.sv
module sampler_cfg_datapath
  import sampler_cfg_pkg::*;
#(
  parameter int DELAY_W     = 4,
  parameter int DELAY_RESET = 8,
  parameter int ARR_SEL_W   = 2,
  parameter int ID_W        = 2,
  localparam int SW_W       = ARR_SEL_W + ID_W,
  localparam int CNT_W      = ARR_SEL_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  dataMode_e          modeState,
  input  logic [SW_W-1:0]    switches,
  input  logic               fifoEmpty,
  input  logic               fifoAlmostEmpty,
  input  logic               fifoAlmostFull,
  input  logic               fifoFull,
  output logic [DELAY_W-1:0] delayIdx,
  output logic [CNT_W-1:0]   arrayCount,
  output logic [ID_W-1:0]    boardId,
  output logic [DELAY_W-1:0] delayLeds,
  output logic [RGB_W-1:0]   rgbA,
  output logic [RGB_W-1:0]   rgbB
);

  localparam logic [DELAY_W-1:0] DELAY_MAX  = {DELAY_W{1'b1}};
  localparam logic [DELAY_W-1:0] DELAY_MIN  = '0;
  localparam logic [DELAY_W-1:0] DELAY_INIT = DELAY_W'(DELAY_RESET);

  logic [RGB_W-1:0] modeColour;
  logic [RGB_W-1:0] fifoColourA;
  logic [RGB_W-1:0] fifoColourB;

  // Saturating delay index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayIdx <= DELAY_INIT;
    end else if (strobes.delayUp && delayIdx != DELAY_MAX) begin
      delayIdx <= delayIdx + 1'b1;
    end else if (strobes.delayDown && delayIdx != DELAY_MIN) begin
      delayIdx <= delayIdx - 1'b1;
    end
  end

  // Registered switch decode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arrayCount <= CNT_W'(1);
      boardId    <= '0;
    end else begin
      arrayCount <= {1'b0, switches[ARR_SEL_W-1:0]} + CNT_W'(1);
      boardId    <= switches[SW_W-1:ARR_SEL_W];
    end
  end

  // Delay LED row, one LED per index bit
  for (genvar b = 0; b < DELAY_W; b++) begin : g_led
    assign delayLeds[b] = delayIdx[b];
  end

  always_comb begin
    modeColour = '0;
    unique case (modeState)
      MODE_SIM_ID:  modeColour[RED_BIT] = 1'b1;
      MODE_REAL_ID: begin
        modeColour[RED_BIT] = 1'b1;
        modeColour[GRN_BIT] = 1'b1;
      end
      default:      modeColour = '0;
    endcase
  end

  always_comb begin
    fifoColourA          = '0;
    fifoColourB          = '0;
    fifoColourA[RED_BIT] = fifoAlmostFull;
    fifoColourA[BLU_BIT] = fifoFull;
    fifoColourB[GRN_BIT] = fifoAlmostEmpty;
    fifoColourB[BLU_BIT] = fifoEmpty;
  end

  assign rgbA = modeColour | fifoColourA;
  assign rgbB = modeColour | fifoColourB;

endmodule

// File: rtl/sampler_cfg_ctrl.sv
module sampler_cfg_ctrl
  import sampler_cfg_pkg::*;
#(
  parameter int DELAY_W     = 4,
  parameter int DELAY_RESET = 8,
  parameter int ARR_SEL_W   = 2,
  parameter int ID_W        = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   incPress,
  input  logic                   decPress,
  input  logic                   modePress,
  input  logic [ARR_SEL_W+ID_W-1:0] switches,
  input  logic                   fifoEmpty,
  input  logic                   fifoAlmostEmpty,
  input  logic                   fifoAlmostFull,
  input  logic                   fifoFull,
  output logic [DELAY_W-1:0]     delayIdx,
  output logic [1:0]             dataMode,
  output logic [ARR_SEL_W:0]     arrayCount,
  output logic [ID_W-1:0]        boardId,
  output logic [DELAY_W-1:0]     delayLeds,
  output logic [2:0]             rgbA,
  output logic [2:0]             rgbB
);

  ctrlStrobes_t strobes;
  dataMode_e    modeState;

  sampler_cfg_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .incPress  (incPress),
    .decPress  (decPress),
    .modePress (modePress),
    .strobes   (strobes),
    .modeState (modeState)
  );

  sampler_cfg_datapath #(
    .DELAY_W     (DELAY_W),
    .DELAY_RESET (DELAY_RESET),
    .ARR_SEL_W   (ARR_SEL_W),
    .ID_W        (ID_W)
  ) u_datapath (
    .clk             (clk),
    .rstN            (rstN),
    .strobes         (strobes),
    .modeState       (modeState),
    .switches        (switches),
    .fifoEmpty       (fifoEmpty),
    .fifoAlmostEmpty (fifoAlmostEmpty),
    .fifoAlmostFull  (fifoAlmostFull),
    .fifoFull        (fifoFull),
    .delayIdx        (delayIdx),
    .arrayCount      (arrayCount),
    .boardId         (boardId),
    .delayLeds       (delayLeds),
    .rgbA            (rgbA),
    .rgbB            (rgbB)
  );

  assign dataMode = modeState;

endmodule

// File: rtl/sampler_cfg_ctrl_checker.sv
module sampler_cfg_ctrl_checker (
  input logic       clk,
  input logic       rstN,
  input logic       incPress,
  input logic       decPress,
  input logic       modePress,
  input logic [3:0] switches,
  input logic       fifoEmpty,
  input logic       fifoAlmostEmpty,
  input logic       fifoAlmostFull,
  input logic       fifoFull,
  input logic [3:0] delayIdx,
  input logic [1:0] dataMode,
  input logic [2:0] arrayCount,
  input logic [1:0] boardId,
  input logic [3:0] delayLeds,
  input logic [2:0] rgbA,
  input logic [2:0] rgbB
);

  assert_inc_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (incPress && !decPress && delayIdx != 4'd15) |=> delayIdx == $past(delayIdx) + 4'd1);

  assert_dec_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (decPress && !incPress && delayIdx != 4'd0) |=> delayIdx == $past(delayIdx) - 4'd1);

  assert_sat_top_R3: assert property (@(posedge clk) disable iff (!rstN)
    (incPress && delayIdx == 4'd15) |=> delayIdx == 4'd15);

  assert_sat_bottom_R3: assert property (@(posedge clk) disable iff (!rstN)
    (decPress && delayIdx == 4'd0) |=> delayIdx == 4'd0);

  assert_cancel_R11: assert property (@(posedge clk) disable iff (!rstN)
    (incPress == decPress) |=> $stable(delayIdx));

  assert_mode_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    modePress |=> dataMode == (($past(dataMode) == 2'd2) ? 2'd0 : $past(dataMode) + 2'd1));

  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !modePress |=> $stable(dataMode));

  assert_mode_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    dataMode != 2'd3);

  assert_array_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> arrayCount == {1'b0, $past(switches[1:0])} + 3'd1);

  assert_board_id_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> boardId == $past(switches[3:2]));

  assert_fifo_colours_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rgbA[2] >= fifoAlmostFull) && (rgbA[0] >= fifoFull) &&
    (rgbB[1] >= fifoAlmostEmpty) && (rgbB[0] >= fifoEmpty));

endmodule

bind sampler_cfg_ctrl sampler_cfg_ctrl_checker u_checker (
  .clk             (clk),
  .rstN            (rstN),
  .incPress        (incPress),
  .decPress        (decPress),
  .modePress       (modePress),
  .switches        (switches),
  .fifoEmpty       (fifoEmpty),
  .fifoAlmostEmpty (fifoAlmostEmpty),
  .fifoAlmostFull  (fifoAlmostFull),
  .fifoFull        (fifoFull),
  .delayIdx        (delayIdx),
  .dataMode        (dataMode),
  .arrayCount      (arrayCount),
  .boardId         (boardId),
  .delayLeds       (delayLeds),
  .rgbA            (rgbA),
  .rgbB            (rgbB)
);

// File: tb/test_sampler_cfg_ctrl.sv
module test_sampler_cfg_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       incPress = 1'b0, decPress = 1'b0, modePress = 1'b0;
  logic [3:0] switches = 4'b1011;
  logic       fifoEmpty = 1'b0, fifoAlmostEmpty = 1'b0;
  logic       fifoAlmostFull = 1'b0, fifoFull = 1'b0;
  logic [3:0] delayIdx, delayLeds;
  logic [1:0] dataMode, boardId;
  logic [2:0] arrayCount, rgbA, rgbB;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sampler_cfg_ctrl i_sampler_cfg_ctrl (
    .clk(clk), .rstN(rstN),
    .incPress(incPress), .decPress(decPress), .modePress(modePress),
    .switches(switches),
    .fifoEmpty(fifoEmpty), .fifoAlmostEmpty(fifoAlmostEmpty),
    .fifoAlmostFull(fifoAlmostFull), .fifoFull(fifoFull),
    .delayIdx(delayIdx), .dataMode(dataMode), .arrayCount(arrayCount),
    .boardId(boardId), .delayLeds(delayLeds), .rgbA(rgbA), .rgbB(rgbB)
  );

  task automatic check(input string req, input int actual, input int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic pressInc();
    @(negedge clk); incPress = 1'b1;
    @(negedge clk); incPress = 1'b0;
  endtask

  task automatic pressDec();
    @(negedge clk); decPress = 1'b1;
    @(negedge clk); decPress = 1'b0;
  endtask

  task automatic pressMode();
    @(negedge clk); modePress = 1'b1;
    @(negedge clk); modePress = 1'b0;
  endtask

  task automatic setFifo(input logic e, input logic ae, input logic af, input logic f);
    fifoEmpty = e; fifoAlmostEmpty = ae; fifoAlmostFull = af; fifoFull = f;
    #1;
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 delay in reset", delayIdx, 8);
    check("R1 mode in reset", dataMode, 0);
    check("R1 array count in reset", arrayCount, 1);
    check("R1 board id in reset", boardId, 0);
    check("R4 leds at reset", delayLeds, 4'b1000);
    check("R6 rgbA off in mode 0", rgbA, 0);
    check("R6 rgbB off in mode 0", rgbB, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 delay after release", delayIdx, 8);
    check("R7 array count sw=11", arrayCount, 4);
    check("R8 board id sw=10", boardId, 2);
  endtask

  task automatic testStep();
    pressInc();
    check("R2 inc to 9", delayIdx, 9);
    check("R4 leds at 9", delayLeds, 4'b1001);
    pressDec();
    check("R2 dec to 8", delayIdx, 8);
    pressDec();
    check("R2 dec to 7", delayIdx, 7);
    check("R4 leds at 7", delayLeds, 4'b0111);
  endtask

  task automatic testSaturate();
    for (int i = 0; i < 12; i++) pressInc();
    check("R3 top saturation", delayIdx, 15);
    check("R4 leds at 15", delayLeds, 4'b1111);
    for (int i = 0; i < 20; i++) pressDec();
    check("R3 bottom saturation", delayIdx, 0);
    pressInc();
    check("R3 leaves bottom", delayIdx, 1);
  endtask

  task automatic testCancel();
    pressInc(); pressInc();
    @(negedge clk); incPress = 1'b1; decPress = 1'b1;
    @(negedge clk); incPress = 1'b0; decPress = 1'b0;
    check("R11 simultaneous press", delayIdx, 3);
  endtask

  task automatic testModes();
    setFifo(0, 0, 0, 0);
    pressMode();
    check("R5 mode 1", dataMode, 1);
    check("R6 rgbA red", rgbA, 3'b100);
    check("R6 rgbB red", rgbB, 3'b100);
    pressMode();
    check("R5 mode 2", dataMode, 2);
    check("R6 rgbA yellow", rgbA, 3'b110);
    check("R6 rgbB yellow", rgbB, 3'b110);
    pressMode();
    check("R5 wrap to 0", dataMode, 0);
    check("R6 rgbA off", rgbA, 0);
    pressMode();
    check("R5 mode 1 again", dataMode, 1);
    pressMode(); pressMode();
    check("R5 back to 0", dataMode, 0);
    check("R5 delay untouched", delayIdx, 3);
  endtask

  task automatic testSwitches();
    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      switches = 4'(s);
      #1;
      check("R7 array count before edge", arrayCount, ((s + 15) % 16 % 4) + 1);
      @(negedge clk);
      check("R7 array count", arrayCount, (s % 4) + 1);
      check("R8 board id", boardId, s / 4);
    end
  endtask

  task automatic testFifo();
    setFifo(1, 0, 0, 0);
    check("R9 empty", {rgbA, rgbB}, {3'b000, 3'b001});
    setFifo(0, 1, 0, 0);
    check("R9 almost empty", {rgbA, rgbB}, {3'b000, 3'b010});
    setFifo(0, 0, 1, 0);
    check("R9 almost full", {rgbA, rgbB}, {3'b100, 3'b000});
    setFifo(0, 0, 0, 1);
    check("R9 full", {rgbA, rgbB}, {3'b001, 3'b000});
    setFifo(1, 1, 1, 1);
    check("R9 all mixed", {rgbA, rgbB}, {3'b101, 3'b011});
    pressMode();
    setFifo(1, 0, 0, 1);
    check("R10 mode 1 or", {rgbA, rgbB}, {3'b101, 3'b101});
    pressMode();
    setFifo(1, 1, 1, 0);
    check("R10 mode 2 or", {rgbA, rgbB}, {3'b110, 3'b111});
    setFifo(0, 0, 0, 0);
    check("R10 mode 2 clear", {rgbA, rgbB}, {3'b110, 3'b110});
  endtask

  initial begin
    testReset();
    testStep();
    testSaturate();
    testCancel();
    testModes();
    testSwitches();
    testFifo();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(4 * 50000);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule